// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations so that most requests avoid a page table read in memory. A requester presents a virtual address. The block splits it into three parts: a page offset, a set index taken from the low page-number bits, and a tag taken from the high page-number bits. All ways of the indexed set are compared at once. The result is registered and returned on the following cycle. A hit gives a physical address formed from the stored physical page number and the untouched offset. A miss raises a request that carries the missing virtual page number.

The surrounding logic fetches the missing entry from the page table. It then returns the entry through a refill port that carries the virtual page number, the physical page number and a valid flag. The refill is placed in the indexed set using these rules, in order:
- an entry that already holds the same tag is rewritten;
- otherwise the lowest free way is used;
- otherwise each set's own rotating pointer chooses the way to replace.

A flush input empties the whole buffer in one cycle, for use on a context switch.

Top module: `xlat_buf`

## Requirements
- R1: The virtual address is split as offset = bits [5:0], set index = bits [7:6] and tag = bits [13:8]; the virtual page number is bits [13:6]. A hit returns {physical page number, offset}, with the offset copied unchanged into bits [5:0].
- R2: When a valid entry in the indexed set holds the request's tag, the cycle after the request shows rsp_valid_o=1, rsp_hit_o=1 and the translated address.
- R3: On a miss, the cycle after the request shows rsp_valid_o=1, rsp_hit_o=0, rsp_paddr_o=0 and miss_req_o=1, and miss_vpn_o holds the request's virtual page number.
- R4: rsp_valid_o is high exactly in the cycle after a cycle in which req_valid_i was high, and low otherwise.
- R5: A refill whose tag is absent from its set goes into the lowest-numbered invalid way of that set. The replacement pointer does not move.
- R6: A refill into a full set with no matching tag replaces the way named by that set's pointer. The pointer is 0 after reset and then steps by one, wrapping, after each such replacement. Other sets' pointers are unaffected.
- R7: A refill whose tag matches a valid entry of its set overwrites that entry. No other entry is evicted and the pointer does not move.
- R8: A refill with its valid flag at 0 leaves the chosen entry invalid. Applied to a present tag, it removes only that translation, and the freed way is reused by the next refill to that set.
- R9: flush_i clears every entry in one cycle. A refill in the same cycle is discarded, and a lookup in the same cycle misses.
- R10: When a refill and a lookup address the same set in the same cycle, the lookup result reflects the set as it is after the refill, including an entry that the refill evicts.
- R11: After reset every entry is invalid, all pointers are 0, and rsp_valid_o and miss_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Invalidate every entry |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | 14 | Virtual address to translate |
| fill_valid_i | input | 1 | Refill entry present |
| fill_vpn_i | input | 8 | Virtual page number of the refill |
| fill_ppn_i | input | 6 | Physical page number of the refill |
| fill_pte_valid_i | input | 1 | Valid flag written with the refill |
| rsp_valid_o | output | 1 | Registered result present |
| rsp_hit_o | output | 1 | Result was a hit |
| rsp_paddr_o | output | 12 | Physical address on hit, zero on miss |
| miss_req_o | output | 1 | Page table fetch needed |
| miss_vpn_o | output | 8 | Virtual page number to fetch |

## Verification
The bench builds the block with its default parameters: 14-bit virtual and 12-bit physical addresses, 64-byte pages, and 4 sets of 4 ways. Because each set holds only four entries, a handful of refills fills a set. This brings the pointer wrap, per-set pointer independence, in-place rewrite and invalidation-then-reuse sequences within reach in a few dozen cycles. The same-cycle collisions are driven directly: refill with lookup on one set, and flush with refill and lookup.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  // How the refill way was chosen
  typedef enum logic [1:0] {
    PICK_MATCH  = 2'd0,
    PICK_FREE   = 2'd1,
    PICK_ROTATE = 2'd2
  } pick_e;
endpackage

// File: rtl/xlat_lookup.sv
`timescale 1ns/1ps
module xlat_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  match_i,
  input  logic [WAY_W-1:0] ptr_i,
  output logic [WAY_W-1:0] way_o,
  output pick_e            pick_o
);
  logic [WAY_W-1:0] match_way, free_way;
  logic             any_match, any_free;

  always_comb begin
    match_way = '0;
    any_match = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!any_match && match_i[i]) begin
        match_way = WAY_W'(i);
        any_match = 1'b1;
      end
    end
  end

  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!any_free && !vld_i[i]) begin
        free_way = WAY_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_match) begin
      way_o  = match_way;
      pick_o = PICK_MATCH;
    end else if (any_free) begin
      way_o  = free_way;
      pick_o = PICK_FREE;
    end else begin
      way_o  = ptr_i;
      pick_o = PICK_ROTATE;
    end
  end
endmodule

// File: rtl/xlat_set.sv
`timescale 1ns/1ps
module xlat_set #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic                        adv_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [PPN_W-1:0]            wr_ppn_i,
  input  logic                        wr_vld_i,
  output logic [WAYS-1:0][TAG_W-1:0]  tags_o,
  output logic [WAYS-1:0][PPN_W-1:0]  ppns_o,
  output logic [WAYS-1:0]             vld_o,
  output logic [WAY_W-1:0]            ptr_o
);
  logic [WAYS-1:0]  vld_d, vld_q;
  logic [WAY_W-1:0] ptr_d, ptr_q;

  // next state
  always_comb begin
    vld_d = vld_q;
    if (flush_i) begin
      vld_d = '0;
    end else if (wr_en_i) begin
      vld_d[wr_way_i] = wr_vld_i;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) begin
      ptr_d = (ptr_q == WAY_W'(WAYS-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  // payload registers, enabled per way, no reset
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic way_we;
    assign way_we = wr_en_i && (wr_way_i == WAY_W'(w));
    always_ff @(posedge clk) begin
      if (way_we) begin
        tags_o[w] <= wr_tag_i;
        ppns_o[w] <= wr_ppn_i;
      end
    end
  end

  assign vld_o = vld_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/xlat_buf.sv
`timescale 1ns/1ps
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_i,
  input  logic                   req_valid_i,
  input  logic [VA_W-1:0]        req_vaddr_i,
  input  logic                   fill_valid_i,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0]  fill_ppn_i,
  input  logic                   fill_pte_valid_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic [PA_W-1:0]        rsp_paddr_o,
  output logic                   miss_req_o,
  output logic [VA_W-OFF_W-1:0]  miss_vpn_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // storage views
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] set_tags;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] set_ppns;
  logic [SETS-1:0][WAYS-1:0]            set_vld;
  logic [SETS-1:0][WAY_W-1:0]           set_ptr;

  // request fields
  logic [OFF_W-1:0] lk_off;
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  assign lk_off = req_vaddr_i[OFF_W-1:0];
  assign lk_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

  // refill fields
  logic [IDX_W-1:0] fl_idx;
  logic [TAG_W-1:0] fl_tag;
  assign fl_idx = fill_vpn_i[IDX_W-1:0];
  assign fl_tag = fill_vpn_i[VPN_W-1:IDX_W];

  // refill way selection
  logic [WAYS-1:0]  fl_match;
  logic [WAY_W-1:0] fl_way;
  pick_e            fl_pick;
  logic             fill_go;

  assign fill_go = fill_valid_i && !flush_i;

  xlat_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_cmp (
    .tags_i (set_tags[fl_idx]),
    .vld_i  (set_vld[fl_idx]),
    .tag_i  (fl_tag),
    .match_o(fl_match)
  );

  xlat_victim #(.WAYS(WAYS)) u_victim (
    .vld_i  (set_vld[fl_idx]),
    .match_i(fl_match),
    .ptr_i  (set_ptr[fl_idx]),
    .way_o  (fl_way),
    .pick_o (fl_pick)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = fill_go && (fl_idx == IDX_W'(s));
    xlat_set #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush_i),
      .wr_en_i (sel),
      .adv_i   (sel && (fl_pick == PICK_ROTATE)),
      .wr_way_i(fl_way),
      .wr_tag_i(fl_tag),
      .wr_ppn_i(fill_ppn_i),
      .wr_vld_i(fill_pte_valid_i),
      .tags_o  (set_tags[s]),
      .ppns_o  (set_ppns[s]),
      .vld_o   (set_vld[s]),
      .ptr_o   (set_ptr[s])
    );
  end

  // lookup sees the set as it will be after this cycle's refill and flush
  logic [WAYS-1:0][TAG_W-1:0] eff_tags;
  logic [WAYS-1:0][PPN_W-1:0] eff_ppns;
  logic [WAYS-1:0]            eff_vld;

  always_comb begin
    eff_tags = set_tags[lk_idx];
    eff_ppns = set_ppns[lk_idx];
    eff_vld  = set_vld[lk_idx];
    if (fill_go && (fl_idx == lk_idx)) begin
      eff_tags[fl_way] = fl_tag;
      eff_ppns[fl_way] = fill_ppn_i;
      eff_vld[fl_way]  = fill_pte_valid_i;
    end
    if (flush_i) begin
      eff_vld = '0;
    end
  end

  logic [WAYS-1:0]  lk_match;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;

  xlat_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_cmp (
    .tags_i (eff_tags),
    .vld_i  (eff_vld),
    .tag_i  (lk_tag),
    .match_o(lk_match)
  );

  assign lk_hit = |lk_match;

  always_comb begin
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_match[w]) begin
        lk_ppn = lk_ppn | eff_ppns[w];
      end
    end
  end

  // response registers
  logic             rv_d, rv_q;
  logic             hit_d, hit_q;
  logic [PA_W-1:0]  pa_d, pa_q;
  logic [VPN_W-1:0] vpn_d, vpn_q;

  always_comb begin
    rv_d  = req_valid_i;
    hit_d = req_valid_i && lk_hit;
    pa_d  = hit_d ? {lk_ppn, lk_off} : '0;
    vpn_d = req_valid_i ? lk_vpn : vpn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q  <= 1'b0;
      hit_q <= 1'b0;
      pa_q  <= '0;
      vpn_q <= '0;
    end else begin
      rv_q  <= rv_d;
      hit_q <= hit_d;
      pa_q  <= pa_d;
      vpn_q <= vpn_d;
    end
  end

  assign rsp_valid_o = rv_q;
  assign rsp_hit_o   = hit_q;
  assign rsp_paddr_o = pa_q;
  assign miss_req_o  = rv_q && !hit_q;
  assign miss_vpn_o  = vpn_q;
endmodule

// File: rtl/xlat_buf_chk.sv
`timescale 1ns/1ps
module xlat_buf_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  req_valid_i,
  input logic [VA_W-1:0]       req_vaddr_i,
  input logic                  rsp_valid_o,
  input logic                  rsp_hit_o,
  input logic [PA_W-1:0]       rsp_paddr_o,
  input logic                  miss_req_o,
  input logic [VA_W-OFF_W-1:0] miss_vpn_o
);
  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> rsp_valid_o);

  assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !rsp_valid_o);

  assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (!rsp_hit_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  assert_miss_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (miss_req_o && rsp_paddr_o == '0));

  assert_miss_vpn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (miss_vpn_o == $past(req_vaddr_i[VA_W-1:OFF_W])));

  assert_flush_forces_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && flush_i) |=> !rsp_hit_o);
endmodule

bind xlat_buf xlat_buf_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush_i    (flush_i),
  .req_valid_i(req_valid_i),
  .req_vaddr_i(req_vaddr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_paddr_o(rsp_paddr_o),
  .miss_req_o (miss_req_o),
  .miss_vpn_o (miss_vpn_o)
);

// File: tb/tb_xlat_buf.sv
`timescale 1ns/1ps
module tb_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        req_valid;
  logic [13:0] vaddr;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic [5:0]  fill_ppn;
  logic        fill_pv;
  logic        rsp_valid, rsp_hit, miss_req;
  logic [11:0] rsp_paddr;
  logic [7:0]  miss_vpn;

  always #2.5 clk = ~clk;

  xlat_buf dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_vaddr_i(vaddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn),
    .fill_ppn_i(fill_ppn), .fill_pte_valid_i(fill_pv),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_paddr_o(rsp_paddr),
    .miss_req_o(miss_req), .miss_vpn_o(miss_vpn)
  );

  typedef struct {
    bit          hit;
    logic [11:0] pa;
    logic [7:0]  vpn;
    string       rq;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [13:0] mkva(input int t, input int s, input int o);
    return {6'(t), 2'(s), 6'(o)};
  endfunction

  task automatic step(input bit rq, input logic [13:0] a,
                      input bit fv, input logic [7:0] fvpn, input logic [5:0] fppn,
                      input bit fpv, input bit fl,
                      input bit eh, input logic [5:0] eppn, input string rn);
    exp_t e;
    @(negedge clk);
    req_valid  = rq;
    vaddr      = a;
    fill_valid = fv;
    fill_vpn   = fvpn;
    fill_ppn   = fppn;
    fill_pv    = fpv;
    flush      = fl;
    if (rq) begin
      e.hit = eh;
      e.pa  = eh ? {eppn, a[5:0]} : 12'h000;
      e.vpn = a[13:6];
      e.rq  = rn;
      q.push_back(e);
    end
  endtask

  task automatic look(input int t, input int s, input int o, input bit eh,
                      input logic [5:0] eppn, input string rn);
    step(1'b1, mkva(t, s, o), 1'b0, 8'h00, 6'h00, 1'b0, 1'b0, eh, eppn, rn);
  endtask

  task automatic fill(input int t, input int s, input logic [5:0] p, input bit pv);
    step(1'b0, 14'h0, 1'b1, {6'(t), 2'(s)}, p, pv, 1'b0, 1'b0, 6'h00, "");
  endtask

  task automatic idle();
    step(1'b0, 14'h0, 1'b0, 8'h00, 6'h00, 1'b0, 1'b0, 1'b0, 6'h00, "");
  endtask

  task automatic check(input bit ok, input string rn, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rn, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (rsp_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R4 response without request", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rsp_hit == e.hit && rsp_paddr == e.pa &&
                miss_req == !e.hit && (e.hit || miss_vpn == e.vpn),
                e.rq, {rsp_hit, rsp_paddr}, {e.hit, e.pa});
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; req_valid = 0; vaddr = 0;
    fill_valid = 0; fill_vpn = 0; fill_ppn = 0; fill_pv = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R11 rsp_valid in reset", rsp_valid, 0);
    check(miss_req == 1'b0, "R11 miss_req in reset", miss_req, 0);
    rst_n = 1'b1;

    // R11 R3: empty after reset, miss reports vpn
    look(3, 1, 5, 0, 0, "R11 empty after reset");
    look(63, 3, 63, 0, 0, "R3 miss vpn top");
    idle();
    @(negedge clk);
    check(rsp_valid == 1'b0, "R4 idle keeps rsp low", rsp_valid, 0);

    // R5: free ways in order, set 0
    fill(10, 0, 6'd20, 1); fill(11, 0, 6'd21, 1);
    fill(12, 0, 6'd22, 1); fill(13, 0, 6'd23, 1);
    look(11, 0, 6'h2A, 1, 6'd21, "R1 R2 hit offset 2A");
    look(13, 0, 6'h3F, 1, 6'd23, "R2 hit offset 3F");
    look(10, 0, 0, 1, 6'd20, "R5 first way kept");
    look(10, 1, 0, 0, 0, "R1 set index separates");

    // R6: rotation in set 0 starts at way 0
    fill(14, 0, 6'd24, 1);
    look(10, 0, 1, 0, 0, "R6 way0 evicted");
    look(14, 0, 2, 1, 6'd24, "R6 new entry");
    look(11, 0, 3, 1, 6'd21, "R6 way1 kept");
    fill(15, 0, 6'd25, 1);
    look(11, 0, 4, 0, 0, "R6 way1 evicted next");
    look(12, 0, 5, 1, 6'd22, "R6 way2 kept");

    // R6: set 1 pointer independent
    fill(1, 1, 6'd1, 1); fill(2, 1, 6'd2, 1);
    fill(3, 1, 6'd3, 1); fill(4, 1, 6'd4, 1);
    fill(5, 1, 6'd5, 1);
    look(1, 1, 9, 0, 0, "R6 set1 own pointer");
    look(2, 1, 9, 1, 6'd2, "R6 set1 way1 kept");
    look(5, 1, 9, 1, 6'd5, "R6 set1 new entry");

    // R7: matching refill rewrites in place, pointer stays at 2
    fill(12, 0, 6'd30, 1);
    look(12, 0, 7, 1, 6'd30, "R7 rewritten ppn");
    look(13, 0, 7, 1, 6'd23, "R7 no eviction 13");
    look(14, 0, 7, 1, 6'd24, "R7 no eviction 14");
    look(15, 0, 7, 1, 6'd25, "R7 no eviction 15");
    fill(16, 0, 6'd26, 1);
    look(12, 0, 8, 0, 0, "R7 pointer unchanged");
    look(13, 0, 8, 1, 6'd23, "R7 way3 kept");

    // R8: invalidate tag 15 (way1), then reuse freed way
    fill(15, 0, 6'd0, 0);
    look(15, 0, 0, 0, 0, "R8 invalidated");
    fill(17, 0, 6'd27, 1);
    look(13, 0, 1, 1, 6'd23, "R8 R5 freed way reused 13");
    look(14, 0, 1, 1, 6'd24, "R8 freed way reused 14");
    look(16, 0, 1, 1, 6'd26, "R8 freed way reused 16");
    look(17, 0, 1, 1, 6'd27, "R8 new entry");

    // R10: refill and lookup on one set in one cycle
    step(1'b1, mkva(18, 0, 6'h11), 1'b1, {6'd18, 2'd0}, 6'd28, 1'b1, 1'b0,
         1'b1, 6'd28, "R10 bypass hit");
    look(13, 0, 2, 0, 0, "R10 way3 replaced");
    step(1'b1, mkva(14, 0, 6'h12), 1'b1, {6'd19, 2'd0}, 6'd29, 1'b1, 1'b0,
         1'b0, 6'd0, "R10 evicted entry misses");
    look(19, 0, 3, 1, 6'd29, "R10 refill stored");
    look(16, 0, 3, 1, 6'd26, "R10 way2 kept");

    // R9: flush beats refill and lookup
    step(1'b1, mkva(16, 0, 6'h05), 1'b1, {6'd7, 2'd2}, 6'd9, 1'b1, 1'b1,
         1'b0, 6'd0, "R9 lookup during flush");
    look(7, 2, 0, 0, 0, "R9 refill dropped");
    look(17, 0, 0, 0, 0, "R9 set0 cleared");
    look(5, 1, 0, 0, 0, "R9 set1 cleared");
    idle();
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R4 all responses seen", q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule